// File: doc/BRIEF.md
# Message and Level Interrupt Source Controller with Coalescing State

This block keeps the state of a small group of interrupt sources and decides when each of them is offered to a presentation controller. Every source has a priority, a target server and a type (message or level), all supplied as static configuration inputs. Each source also holds a two-bit coalescing state (a presented bit P and a queued bit Q), a resend flag and a masked-pending flag. Message triggers, end-of-interrupt (EOI) requests and bounce notices from the presentation side arrive as 24-bit source numbers. Each is applied to the source state in the cycle it arrives and leaves a per-source work flag behind. Events are therefore never dropped while an offer is in flight.

A single controller state machine serves one source at a time. It moves through **IDLE** (pick work), **LOOKUP** (read the source's priority and server), **OFFER** (one-cycle delivery pulse), **WAIT_RESP** (wait for accept or refuse) and **MARK_RESEND** (record a refusal). Its transitions are: IDLE→LOOKUP when any work is pending; LOOKUP→IDLE when the source is masked; LOOKUP→OFFER otherwise; OFFER→WAIT_RESP always; WAIT_RESP→IDLE on accept; WAIT_RESP→MARK_RESEND on refuse; MARK_RESEND→IDLE always. A refused source is parked with its resend flag set and raises a resend-pending bit for its server. A later scan request for that server replays it.

Top module: `pq_intsrc_ctrl`

## Requirements
- R1: The coalescing state holds P in bit 0 and Q in bit 1, and is 00 after reset. A message trigger replaces it with ((old << 1) & 2'b11) | 2'b01. An offer is queued only when the result is exactly 2'b01.
- R2: While P is set, further message triggers to that source only set Q and produce no additional offer.
- R3: An EOI to a message source shifts the state right by one, moving Q into P and clearing Q. If P is then 1, the source is offered again; otherwise nothing is offered.
- R4: For a level source, P follows `lvl_line` and Q stays 0. A 0→1 change of the line queues an offer. An EOI queues a new offer only while P is still 1. Message triggers to a level source have no effect.
- R5: A source whose priority is 8'hFF is never offered; it sets its masked-pending flag instead. That flag makes the source eligible again as soon as its priority is no longer 8'hFF, and this holds for normal delivery, bounce and resend alike.
- R6: A refused offer sets the source's resend flag and sets `resend_pend[server]`. The source is not offered again until a scan for that server.
- R7: A scan request clears `resend_pend[scan_server]` and offers every source of that server whose resend flag was set, once each, clearing the flag. Sources of other servers are not replayed.
- R8: A bounce notice for a source sends it through the full delivery path, including the mask check, without changing its coalescing state.
- R9: When several kinds of work wait, EOI work is served first, then trigger, bounce and unmasked work, then scan work. Within a kind, the lowest source index wins.
- R10: Source i has number SRC_BASE + i. Event numbers outside SRC_BASE..SRC_BASE+N_SRC-1, including 0, are ignored.
- R11: `dlv_valid` is a one-cycle pulse. It rises on the third rising edge after an event is sampled by an idle controller. A response counts only on a cycle after the pulse, and only one offer is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prio | input | N_SRC*PRIO_W | Priority per source; source i at bits [i*PRIO_W +: PRIO_W]; 8'hFF means masked |
| cfg_server | input | N_SRC*SRV_W | Target server per source |
| cfg_level | input | N_SRC | 1 = level source, 0 = message source |
| lvl_line | input | N_SRC | Input line state of level sources |
| trig_valid | input | 1 | Message trigger strobe |
| trig_num | input | NUM_W | Source number of the trigger |
| eoi_valid | input | 1 | EOI strobe |
| eoi_num | input | NUM_W | Source number being EOI'd |
| bnc_valid | input | 1 | Bounce strobe (accepted interrupt displaced later) |
| bnc_num | input | NUM_W | Source number bounced back |
| scan_valid | input | 1 | Resend scan request |
| scan_server | input | SRV_W | Server whose parked sources are replayed |
| rsp_valid | input | 1 | Response to the outstanding offer |
| rsp_accept | input | 1 | 1 = accepted, 0 = refused |
| dlv_valid | output | 1 | Offer pulse |
| dlv_num | output | NUM_W | Offered source number |
| dlv_prio | output | PRIO_W | Offered priority |
| dlv_server | output | SRV_W | Offered target server |
| resend_pend | output | 2**SRV_W | Per-server flag: parked sources await a scan |

## Verification
The bench targets the coalescing corners. It sends a second and a third trigger while P is set, which a design that re-offered on every trigger would turn into extra offers. It sends an EOI with Q set and one with Q clear, where a wrong shift either loses the queued interrupt or invents one. It also drives a level source with the line held and then released, and a masked source that later gets unmasked, where a design that dropped the masked-pending flag would lose the interrupt forever. Refusal and replay are checked per server: a scan of the wrong server must replay nothing, and a second scan must not replay a source twice. Simultaneous EOI and trigger events, and trigger plus scan, check that service order follows the stated ranking rather than source index alone.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_OFFER,
        ST_WAIT_RESP,
        ST_MARK_RESEND
    } isc_state_e;

    // Coalescing state value with only the presented bit set
    localparam logic [1:0] PQ_P = 2'b01;

endpackage

// File: rtl/isc_first_set.sv
module isc_first_set #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/isc_src_bank.sv
module isc_src_bank
    import isc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] is_level,
    input  logic [N-1:0] line_in,
    input  logic [N-1:0] trig_hit,
    input  logic [N-1:0] eoi_hit,
    input  logic [N-1:0] bnc_hit,
    input  logic [N-1:0] masked_now,
    input  logic [N-1:0] pick_oh,
    input  logic [N-1:0] resend_set,
    input  logic [N-1:0] mask_set,
    input  logic         scan_load,
    input  logic [N-1:0] scan_sel,
    output logic [N-1:0] eoi_work,
    output logic [N-1:0] trig_elig,
    output logic [N-1:0] scan_work
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic [1:0] pq_q, pq_mid, pq_nx;
        logic       eoi_set, trig_set;
        logic       ew_q, tw_q, rs_q, mp_q, sw_q;

        always_comb begin
            if (is_level[g]) begin
                pq_mid   = pq_q;
                pq_nx    = {1'b0, line_in[g]};
                eoi_set  = eoi_hit[g] & pq_q[0];
                trig_set = (line_in[g] & ~pq_q[0]) | bnc_hit[g];
            end else begin
                // EOI is applied before a same-cycle trigger
                pq_mid   = eoi_hit[g] ? (pq_q >> 1) : pq_q;
                pq_nx    = trig_hit[g] ? (((pq_mid << 1) & 2'b11) | PQ_P) : pq_mid;
                eoi_set  = eoi_hit[g] & pq_mid[0];
                trig_set = (trig_hit[g] && (pq_nx == PQ_P)) | bnc_hit[g];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pq_q <= '0;
                ew_q <= 1'b0;
                tw_q <= 1'b0;
                rs_q <= 1'b0;
                mp_q <= 1'b0;
                sw_q <= 1'b0;
            end else begin
                pq_q <= pq_nx;
                ew_q <= (ew_q & ~pick_oh[g]) | eoi_set;
                tw_q <= (tw_q & ~pick_oh[g]) | trig_set;
                rs_q <= (rs_q & ~pick_oh[g]) | resend_set[g];
                mp_q <= (mp_q & ~pick_oh[g]) | mask_set[g];
                sw_q <= (sw_q & ~pick_oh[g]) | (scan_load & scan_sel[g] & rs_q);
            end
        end

        assign eoi_work[g]  = ew_q;
        assign trig_elig[g] = tw_q | (mp_q & ~masked_now[g]);
        assign scan_work[g] = sw_q;
    end
endmodule

// File: rtl/pq_intsrc_ctrl.sv
module pq_intsrc_ctrl
    import isc_pkg::*;
#(
    parameter int               N_SRC    = 16,
    parameter int               SRV_W    = 2,
    parameter int               PRIO_W   = 8,
    parameter int               NUM_W    = 24,
    parameter logic [NUM_W-1:0] SRC_BASE = 24'h000010
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC*PRIO_W-1:0]   cfg_prio,
    input  logic [N_SRC*SRV_W-1:0]    cfg_server,
    input  logic [N_SRC-1:0]          cfg_level,
    input  logic [N_SRC-1:0]          lvl_line,
    input  logic                      trig_valid,
    input  logic [NUM_W-1:0]          trig_num,
    input  logic                      eoi_valid,
    input  logic [NUM_W-1:0]          eoi_num,
    input  logic                      bnc_valid,
    input  logic [NUM_W-1:0]          bnc_num,
    input  logic                      scan_valid,
    input  logic [SRV_W-1:0]          scan_server,
    input  logic                      rsp_valid,
    input  logic                      rsp_accept,
    output logic                      dlv_valid,
    output logic [NUM_W-1:0]          dlv_num,
    output logic [PRIO_W-1:0]         dlv_prio,
    output logic [SRV_W-1:0]          dlv_server,
    output logic [(1<<SRV_W)-1:0]     resend_pend
);
    localparam int                IW          = $clog2(N_SRC);
    localparam int                N_SRV       = 1 << SRV_W;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

    isc_state_e          state, nxt;
    logic [IW-1:0]       cur_idx;
    logic [PRIO_W-1:0]   cur_prio;
    logic [SRV_W-1:0]    cur_srv;
    logic [N_SRV-1:0]    resend_nx;

    logic [N_SRC-1:0] trig_hit, eoi_hit, bnc_hit, masked_now, scan_sel;
    logic [N_SRC-1:0] eoi_work, trig_elig, scan_work;
    logic [N_SRC-1:0] pick_oh, cur_oh, resend_set, mask_set;
    logic             eoi_any, trig_any, scan_any, pick_valid;
    logic [IW-1:0]    eoi_idx, trig_idx, scan_idx, pick_idx;

    // Number decode and per-source configuration views
    for (genvar g = 0; g < N_SRC; g++) begin : g_dec
        localparam logic [NUM_W-1:0] MY_NUM = SRC_BASE + NUM_W'(g);
        assign trig_hit[g]   = trig_valid && (trig_num == MY_NUM);
        assign eoi_hit[g]    = eoi_valid  && (eoi_num  == MY_NUM);
        assign bnc_hit[g]    = bnc_valid  && (bnc_num  == MY_NUM);
        assign masked_now[g] = (cfg_prio[g*PRIO_W +: PRIO_W] == PRIO_MASKED);
        assign scan_sel[g]   = (cfg_server[g*SRV_W +: SRV_W] == scan_server);
    end

    isc_src_bank #(.N(N_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_level   (cfg_level),
        .line_in    (lvl_line),
        .trig_hit   (trig_hit),
        .eoi_hit    (eoi_hit),
        .bnc_hit    (bnc_hit),
        .masked_now (masked_now),
        .pick_oh    (pick_oh),
        .resend_set (resend_set),
        .mask_set   (mask_set),
        .scan_load  (scan_valid),
        .scan_sel   (scan_sel),
        .eoi_work   (eoi_work),
        .trig_elig  (trig_elig),
        .scan_work  (scan_work)
    );

    isc_first_set #(.N(N_SRC), .IW(IW)) u_pick_eoi  (.req(eoi_work),  .found(eoi_any),  .idx(eoi_idx));
    isc_first_set #(.N(N_SRC), .IW(IW)) u_pick_trig (.req(trig_elig), .found(trig_any), .idx(trig_idx));
    isc_first_set #(.N(N_SRC), .IW(IW)) u_pick_scan (.req(scan_work), .found(scan_any), .idx(scan_idx));

    // Service ranking: EOI, then trigger/bounce/unmasked, then scan
    always_comb begin
        pick_valid = eoi_any | trig_any | scan_any;
        if (eoi_any)       pick_idx = eoi_idx;
        else if (trig_any) pick_idx = trig_idx;
        else               pick_idx = scan_idx;
    end

    assign cur_oh     = N_SRC'(1) << cur_idx;
    assign pick_oh    = (state == ST_IDLE && pick_valid) ? (N_SRC'(1) << pick_idx) : '0;
    assign resend_set = (state == ST_MARK_RESEND) ? cur_oh : '0;
    assign mask_set   = (state == ST_LOOKUP && masked_now[cur_idx]) ? cur_oh : '0;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        if (pick_valid) nxt = ST_LOOKUP;
            ST_LOOKUP:      nxt = masked_now[cur_idx] ? ST_IDLE : ST_OFFER;
            ST_OFFER:       nxt = ST_WAIT_RESP;
            ST_WAIT_RESP:   if (rsp_valid) nxt = rsp_accept ? ST_IDLE : ST_MARK_RESEND;
            ST_MARK_RESEND: nxt = ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
    end

    // A mark in the same cycle as a scan of that server wins
    always_comb begin
        resend_nx = resend_pend;
        if (scan_valid)               resend_nx[scan_server] = 1'b0;
        if (state == ST_MARK_RESEND)  resend_nx[cur_srv]     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_idx     <= '0;
            cur_prio    <= '0;
            cur_srv     <= '0;
            resend_pend <= '0;
        end else begin
            state       <= nxt;
            resend_pend <= resend_nx;
            if (state == ST_IDLE && pick_valid) cur_idx <= pick_idx;
            if (state == ST_LOOKUP) begin
                cur_prio <= cfg_prio[cur_idx*PRIO_W +: PRIO_W];
                cur_srv  <= cfg_server[cur_idx*SRV_W +: SRV_W];
            end
        end
    end

    always_comb begin
        dlv_valid  = (state == ST_OFFER);
        dlv_num    = SRC_BASE + NUM_W'(cur_idx);
        dlv_prio   = cur_prio;
        dlv_server = cur_srv;
    end
endmodule

// File: rtl/isc_chk.sv
module isc_chk
    import isc_pkg::*;
#(
    parameter int               N_SRC    = 16,
    parameter int               SRV_W    = 2,
    parameter int               PRIO_W   = 8,
    parameter int               NUM_W    = 24,
    parameter logic [NUM_W-1:0] SRC_BASE = 24'h000010
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dlv_valid,
    input logic [NUM_W-1:0]      dlv_num,
    input logic [PRIO_W-1:0]     dlv_prio,
    input logic                  scan_valid,
    input logic [SRV_W-1:0]      scan_server,
    input logic [(1<<SRV_W)-1:0] resend_pend,
    input isc_state_e            state,
    input logic [SRV_W-1:0]      cur_srv
);
    // R11: offer is a single-cycle pulse
    assert_offer_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !dlv_valid);

    // R5: a masked priority never reaches the output
    assert_never_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_prio != {PRIO_W{1'b1}}));

    // R10: offered numbers lie inside the group's range
    assert_num_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((dlv_num >= SRC_BASE) && ((dlv_num - SRC_BASE) < NUM_W'(N_SRC))));

    // R6: a refusal leaves the server's resend flag raised
    assert_refuse_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK_RESEND) |=> resend_pend[$past(cur_srv)]);

    // R7: a scan clears its server's flag unless a mark for it collides
    assert_scan_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !(state == ST_MARK_RESEND && cur_srv == scan_server))
        |=> !resend_pend[$past(scan_server)]);
endmodule

bind pq_intsrc_ctrl isc_chk #(
    .N_SRC(N_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .SRC_BASE(SRC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dlv_valid   (dlv_valid),
    .dlv_num     (dlv_num),
    .dlv_prio    (dlv_prio),
    .scan_valid  (scan_valid),
    .scan_server (scan_server),
    .resend_pend (resend_pend),
    .state       (state),
    .cur_srv     (cur_srv)
);

// File: tb/tb_pq_intsrc_ctrl.sv
module tb_pq_intsrc_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam int          N  = 16;
    localparam int          SW = 2;
    localparam int          PW = 8;
    localparam int          NW = 24;
    localparam logic [23:0] B  = 24'h000010;

    logic              clk, rst_n;
    logic [N*PW-1:0]   cfg_prio;
    logic [N*SW-1:0]   cfg_server;
    logic [N-1:0]      cfg_level, lvl_line;
    logic              trig_valid, eoi_valid, bnc_valid, scan_valid, rsp_valid, rsp_accept;
    logic [NW-1:0]     trig_num, eoi_num, bnc_num;
    logic [SW-1:0]     scan_server;
    logic              dlv_valid;
    logic [NW-1:0]     dlv_num;
    logic [PW-1:0]     dlv_prio;
    logic [SW-1:0]     dlv_server;
    logic [(1<<SW)-1:0] resend_pend;

    int n_chk = 0;
    int n_bad = 0;

    pq_intsrc_ctrl #(.N_SRC(N), .SRV_W(SW), .PRIO_W(PW), .NUM_W(NW), .SRC_BASE(B)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_prio(cfg_prio), .cfg_server(cfg_server),
        .cfg_level(cfg_level), .lvl_line(lvl_line),
        .trig_valid(trig_valid), .trig_num(trig_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .bnc_valid(bnc_valid), .bnc_num(bnc_num),
        .scan_valid(scan_valid), .scan_server(scan_server),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .dlv_valid(dlv_valid), .dlv_num(dlv_num), .dlv_prio(dlv_prio),
        .dlv_server(dlv_server), .resend_pend(resend_pend)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_src(input int idx, input logic [7:0] pr, input logic [1:0] sv, input logic lv);
        cfg_prio[idx*PW +: PW]   = pr;
        cfg_server[idx*SW +: SW] = sv;
        cfg_level[idx]           = lv;
    endtask

    task automatic trig(input logic [23:0] num);
        @(negedge clk); trig_valid = 1'b1; trig_num = num;
        @(negedge clk); trig_valid = 1'b0; trig_num = '0;
    endtask

    task automatic eoi(input logic [23:0] num);
        @(negedge clk); eoi_valid = 1'b1; eoi_num = num;
        @(negedge clk); eoi_valid = 1'b0; eoi_num = '0;
    endtask

    task automatic bnc(input logic [23:0] num);
        @(negedge clk); bnc_valid = 1'b1; bnc_num = num;
        @(negedge clk); bnc_valid = 1'b0; bnc_num = '0;
    endtask

    task automatic scan(input logic [1:0] sv);
        @(negedge clk); scan_valid = 1'b1; scan_server = sv;
        @(negedge clk); scan_valid = 1'b0; scan_server = '0;
    endtask

    task automatic offer(input string req, input logic [23:0] num, input logic [7:0] pr,
                         input logic [1:0] sv, input bit acc);
        for (int k = 0; k < 20 && !dlv_valid; k++) @(negedge clk);
        check({req, " offer seen"}, 32'(dlv_valid), 32'd1);
        if (dlv_valid) begin
            check({req, " number"}, 32'(dlv_num), 32'(num));
            check({req, " priority"}, 32'(dlv_prio), 32'(pr));
            check({req, " server"}, 32'(dlv_server), 32'(sv));
            @(negedge clk); rsp_valid = 1'b1; rsp_accept = acc;
            @(negedge clk); rsp_valid = 1'b0; rsp_accept = 1'b0;
        end
    endtask

    task automatic quiet(input string req, input int cyc);
        bit seen = 1'b0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (dlv_valid) seen = 1'b1;
        end
        check({req, " no offer"}, 32'(seen), 32'd0);
    endtask

    task automatic t_reset();
        check("R11 reset dlv_valid", 32'(dlv_valid), 32'd0);
        check("R6 reset resend_pend", 32'(resend_pend), 32'd0);
    endtask

    task automatic t_trigger();
        set_src(3, 8'h05, 2'd1, 1'b0);
        trig(B + 3);
        check("R11 no offer one edge later", 32'(dlv_valid), 32'd0);
        @(negedge clk);
        check("R11 no offer two edges later", 32'(dlv_valid), 32'd0);
        @(negedge clk);
        check("R11 offer on third edge", 32'(dlv_valid), 32'd1);
        offer("R1 first trigger", B + 3, 8'h05, 2'd1, 1'b1);
        trig(B + 3);
        quiet("R2 second trigger coalesced", 8);
        trig(B + 3);
        quiet("R2 third trigger coalesced", 8);
    endtask

    task automatic t_eoi_msg();
        eoi(B + 3);
        offer("R3 eoi with Q set", B + 3, 8'h05, 2'd1, 1'b1);
        eoi(B + 3);
        quiet("R3 eoi with Q clear", 8);
        trig(B + 3);
        offer("R1 trigger after idle state", B + 3, 8'h05, 2'd1, 1'b1);
        eoi(B + 3);
        quiet("R3 eoi returns to idle", 8);
    endtask

    task automatic t_level();
        set_src(7, 8'h20, 2'd0, 1'b1);
        @(negedge clk); lvl_line[7] = 1'b1;
        offer("R4 line rise", B + 7, 8'h20, 2'd0, 1'b1);
        trig(B + 7);
        quiet("R4 message trigger to level source", 8);
        eoi(B + 7);
        offer("R4 eoi with line high", B + 7, 8'h20, 2'd0, 1'b1);
        @(negedge clk); lvl_line[7] = 1'b0;
        @(negedge clk);
        eoi(B + 7);
        quiet("R4 eoi with line low", 8);
    endtask

    task automatic t_masked();
        set_src(9, 8'hFF, 2'd0, 1'b0);
        trig(B + 9);
        quiet("R5 masked trigger", 10);
        @(negedge clk); set_src(9, 8'h09, 2'd0, 1'b0);
        offer("R5 offered after unmask", B + 9, 8'h09, 2'd0, 1'b1);
        eoi(B + 9);
        quiet("R5 eoi after unmask", 8);
    endtask

    task automatic t_resend();
        set_src(2, 8'h30, 2'd2, 1'b0);
        trig(B + 2);
        offer("R6 first offer", B + 2, 8'h30, 2'd2, 1'b0);
        @(negedge clk);
        check("R6 resend flag for server 2", 32'(resend_pend), 32'h4);
        quiet("R6 no retry before scan", 10);
        scan(2'd1);
        quiet("R7 scan of other server", 8);
        check("R7 other scan keeps flag", 32'(resend_pend), 32'h4);
        scan(2'd2);
        check("R7 scan clears flag", 32'(resend_pend), 32'h0);
        offer("R7 replay", B + 2, 8'h30, 2'd2, 1'b1);
        scan(2'd2);
        quiet("R7 second scan replays nothing", 10);
        eoi(B + 2);
        quiet("R7 eoi after replay", 6);
    endtask

    task automatic t_bounce();
        bnc(B + 3);
        offer("R8 bounce delivered", B + 3, 8'h05, 2'd1, 1'b1);
        trig(B + 3);
        offer("R8 bounce left state idle", B + 3, 8'h05, 2'd1, 1'b1);
        eoi(B + 3);
        quiet("R8 eoi after bounce", 6);
    endtask

    task automatic t_arbitration();
        set_src(5, 8'h11, 2'd0, 1'b0);
        set_src(4, 8'h12, 2'd0, 1'b0);
        trig(B + 5);
        offer("R9 setup", B + 5, 8'h11, 2'd0, 1'b1);
        trig(B + 5);
        quiet("R2 queued for arbitration", 6);
        @(negedge clk);
        trig_valid = 1'b1; trig_num = B + 4;
        eoi_valid  = 1'b1; eoi_num  = B + 5;
        @(negedge clk);
        trig_valid = 1'b0; eoi_valid = 1'b0;
        offer("R9 eoi served first", B + 5, 8'h11, 2'd0, 1'b1);
        offer("R9 trigger served second", B + 4, 8'h12, 2'd0, 1'b1);
        eoi(B + 4);
        eoi(B + 5);
        quiet("R9 cleanup", 6);

        set_src(6, 8'h13, 2'd3, 1'b0);
        set_src(1, 8'h14, 2'd0, 1'b0);
        trig(B + 6);
        offer("R9 refused for scan", B + 6, 8'h13, 2'd3, 1'b0);
        @(negedge clk);
        scan_valid = 1'b1; scan_server = 2'd3;
        trig_valid = 1'b1; trig_num = B + 1;
        @(negedge clk);
        scan_valid = 1'b0; trig_valid = 1'b0;
        offer("R9 trigger before scan", B + 1, 8'h14, 2'd0, 1'b1);
        offer("R9 scan afterwards", B + 6, 8'h13, 2'd3, 1'b1);
        eoi(B + 1);
        eoi(B + 6);
        quiet("R9 cleanup two", 6);
    endtask

    task automatic t_numbers();
        trig(24'h0);
        eoi(24'h0);
        trig(B + 16);
        bnc(B - 1);
        quiet("R10 out of range numbers", 10);
        trig(B);
        offer("R10 lowest number", B, 8'h10, 2'd0, 1'b1);
        trig(B + 15);
        offer("R10 highest number", B + 15, 8'h10, 2'd0, 1'b1);
        eoi(B);
        eoi(B + 15);
        quiet("R10 cleanup", 6);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_prio = '0; cfg_server = '0; cfg_level = '0; lvl_line = '0;
        trig_valid = 1'b0; eoi_valid = 1'b0; bnc_valid = 1'b0; scan_valid = 1'b0;
        trig_num = '0; eoi_num = '0; bnc_num = '0; scan_server = '0;
        rsp_valid = 1'b0; rsp_accept = 1'b0;
        for (int i = 0; i < N; i++) set_src(i, 8'h10, 2'd0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trigger();
        t_eoi_msg();
        t_level();
        t_masked();
        t_resend();
        t_bounce();
        t_arbitration();
        t_numbers();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule